// File: doc/BRIEF.md
# Strobe-Driven FIFO with Flow-Through

This block is a first-in first-out word buffer, 9 bits wide, with a depth parameter of 256, 512 or 1024 words. A producer stores a word by pulsing an active-low write strobe, and a consumer fetches a word by holding an active-low read strobe low. A single system clock samples both strobes. A word is committed on the clock where the write strobe is first seen high after being seen low. The output bus is qualified by an enable signal rather than being driven to high impedance. The bus is enabled while a read is open, and it is released when the read strobe rises. The read pointer advances on that same edge.

Three active-low status flags report empty, full and more-than-half-full. A rewind input returns the read pointer to location zero so that stored data can be sent again. Two boundary cases work without extra handshaking. A read strobe held low on an empty buffer picks up the first word written. A write strobe held low on a full buffer stores its word as soon as a read frees a slot and the strobe rises. The block is fully deterministic, so several copies can be driven from the same strobes to build a wider word, and the flags of any one copy can be used for all of them.

Top module: `strobe_fifo`

## Requirements
- R1: During and right after a synchronous active-high reset, empty_n is 0, full_n is 1, half_n is 1 and dout_oe is 0.
- R2: A word is committed when wr_n is sampled low on one clock and high on the next. The value of din sampled on that second clock is stored. Words read back in the order they were committed.
- R3: A write edge seen while full_n is 0 is ignored: the stored contents and the fill level do not change. Every further word needs a new low-then-high pulse of wr_n.
- R4: On a non-empty buffer, the read opens on the first clock that samples rd_n low. From the next clock, dout_oe is 1 and dout holds the oldest word. When a clock samples rd_n high again, dout_oe returns to 0 and that word is removed.
- R5: While the buffer is empty, a low rd_n leaves dout_oe at 0 and removes nothing.
- R6: If rd_n is held low on an empty buffer, a write opens the read one clock after the commit. dout_oe becomes 1 with the new word, empty_n goes to 1, and empty_n returns to 0 after rd_n rises.
- R7: If wr_n is held low on a full buffer and a read then completes, full_n goes to 1. The following rising edge of wr_n stores the word and full_n returns to 0.
- R8: half_n is 0 exactly when the fill level is greater than DEPTH/2.
- R9: full_n is 0 exactly when the fill level equals DEPTH. empty_n is 0 exactly when the fill level is 0.
- R10: rewind is honoured when it is sampled high with wr_n sampled high on this clock and the last, rd_n high, and no read open. The read pointer then returns to location 0, and the fill level becomes the number of words accepted since reset, capped at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; commits on its rising edge |
| din | input | 9 | Write data |
| rd_n | input | 1 | Read strobe, active low |
| rewind | input | 1 | Retransmit request, active high |
| dout | output | 9 | Read data, meaningful while dout_oe is 1 (zero otherwise) |
| dout_oe | output | 1 | Output enable for dout |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |

## Verification
A write commits on the first clock that sees wr_n high again. The flags reflect that commit immediately after that edge. The bench drives inputs on falling edges and reads the flags on the falling edge after the commit clock. A read needs one clock to open: dout_oe and dout are sampled on the falling edge that follows the clock which first saw rd_n low, and the release is sampled one falling edge after rd_n is raised. Both flow-through cases hold a strobe low across these windows and check the flag on each intermediate falling edge.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // strobe events decoded from the synchronously sampled strobes
    typedef struct packed {
        logic wr_rise;   // wr_n was low last clock, high now
        logic wr_idle;   // wr_n high last clock and now
        logic rd_low;    // rd_n sampled low now
        logic rd_rise;   // rd_n was low last clock, high now
    } strobe_ev_t;

    // internal flags, active high
    typedef struct packed {
        logic empty;
        logic full;
        logic half;
    } flags_t;

    function automatic flags_t calc_flags(input int unsigned level, input int unsigned depth);
        flags_t f;
        f.empty = (level == 0);
        f.full  = (level == depth);
        f.half  = (level > depth / 2);
        return f;
    endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import strobe_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_n,
    input  logic       rd_n,
    output strobe_ev_t ev
);

    logic wr_q;
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    always_comb begin
        ev.wr_rise = !wr_q && wr_n;
        ev.wr_idle = wr_q && wr_n;
        ev.rd_low  = !rd_n;
        ev.rd_rise = !rd_q && rd_n;
    end

endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_ev_t    ev,
    input  logic          rewind,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          do_write,
    output logic          load_out,
    output logic          rd_open,
    output flags_t        flags
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] level;
    logic [CW-1:0] accepted;
    logic          do_read;
    logic          do_rewind;

    always_comb begin
        flags     = calc_flags(int'(level), DEPTH);
        do_write  = ev.wr_rise && !flags.full;
        do_read   = ev.rd_rise && rd_open;
        load_out  = ev.rd_low && !rd_open && !flags.empty;
        do_rewind = rewind && ev.wr_idle && !ev.rd_low && !rd_open;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            level    <= '0;
            accepted <= '0;
            rd_open  <= 1'b0;
        end else begin
            if (do_write) begin
                wptr <= wptr + 1'b1;
                if (accepted != DEPTH_C)
                    accepted <= accepted + 1'b1;
            end
            if (do_rewind) begin
                rptr  <= '0;
                level <= accepted;
            end else begin
                if (do_read)
                    rptr <= rptr + 1'b1;
                level <= level + CW'(do_write) - CW'(do_read);
            end
            rd_open <= ev.rd_low && (rd_open || !flags.empty);
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        level <= DEPTH_C);

    // R3
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.wr_rise && flags.full) |=> $stable(wptr));

    // R4
    read_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.rd_rise && rd_open) |=> (rptr == AW'($past(rptr) + 1'b1)));

    // R10
    rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rewind && ev.wr_idle && !ev.rd_low && !rd_open) |=> (rptr == '0));

    // R5
    empty_no_open_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && !rd_open) |=> !($past(flags.empty) && rd_open) || $past(do_write));

endmodule

// File: rtl/fifo_store.sv
module fifo_store
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          do_write,
    input  logic [AW-1:0] wptr,
    input  word_t         wdata,
    input  logic          load_out,
    input  logic [AW-1:0] rptr,
    output word_t         rdata
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (do_write)
            mem[wptr] <= wdata;
        if (load_out)
            rdata <= mem[rptr];
    end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_n,
    input  logic [8:0] din,
    input  logic       rd_n,
    input  logic       rewind,
    output logic [8:0] dout,
    output logic       dout_oe,
    output logic       empty_n,
    output logic       full_n,
    output logic       half_n
);

    strobe_ev_t    ev;
    flags_t        flags;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          do_write;
    logic          load_out;
    logic          rd_open;
    word_t         rdata;

    strobe_sampler u_sampler (
        .clk  (clk),
        .rst  (rst),
        .wr_n (wr_n),
        .rd_n (rd_n),
        .ev   (ev)
    );

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rewind   (rewind),
        .wptr     (wptr),
        .rptr     (rptr),
        .do_write (do_write),
        .load_out (load_out),
        .rd_open  (rd_open),
        .flags    (flags)
    );

    fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .do_write (do_write),
        .wptr     (wptr),
        .wdata    (din),
        .load_out (load_out),
        .rptr     (rptr),
        .rdata    (rdata)
    );

    always_comb begin
        dout_oe = rd_open;
        dout    = rd_open ? rdata : '0;
        empty_n = !flags.empty;
        full_n  = !flags.full;
        half_n  = !flags.half;
    end

    // R4
    oe_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> empty_n);

    // R8
    full_implies_half_chk: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !half_n);

    // R4
    oe_drops_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> !dout_oe);

endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;

    localparam int DEPTH = 256;
    localparam int NVEC  = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       wr_n = 1'b1;
    logic [8:0] din = '0;
    logic       rd_n = 1'b1;
    logic       rewind = 1'b0;
    logic [8:0] dout;
    logic       dout_oe;
    logic       empty_n;
    logic       full_n;
    logic       half_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_n    (wr_n),
        .din     (din),
        .rd_n    (rd_n),
        .rewind  (rewind),
        .dout    (dout),
        .dout_oe (dout_oe),
        .empty_n (empty_n),
        .full_n  (full_n),
        .half_n  (half_n)
    );

    // bit 9: 1 = read and compare, 0 = write; bits 8:0 = data
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 9'h011}, {1'b0, 9'h122}, {1'b1, 9'h011}, {1'b0, 9'h1FF},
        {1'b1, 9'h122}, {1'b1, 9'h1FF}, {1'b0, 9'h000}, {1'b0, 9'h0A5},
        {1'b1, 9'h000}, {1'b1, 9'h0A5}, {1'b0, 9'h155}, {1'b1, 9'h155}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rewind = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_n = 1'b0;
        @(negedge clk);
        din = d;
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(output logic [8:0] got, output logic oe_seen);
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        oe_seen = dout_oe;
        got = dout;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] got;
        logic       oe;
        int         bad;

        // R1 reset state
        do_reset();
        chk("R1 empty_n", 16'(empty_n), 16'd0);
        chk("R1 full_n", 16'(full_n), 16'd1);
        chk("R1 half_n", 16'(half_n), 16'd1);
        chk("R1 dout_oe", 16'(dout_oe), 16'd0);

        // R2 / R4 vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][9]) begin
                rd(got, oe);
                chk("R4 oe during read", 16'(oe), 16'd1);
                chk("R2 read order", 16'(got), 16'(VEC[i][8:0]));
                chk("R4 oe released", 16'(dout_oe), 16'd0);
            end else begin
                wr(VEC[i][8:0]);
            end
        end
        chk("R9 empty after table", 16'(empty_n), 16'd0);

        // R5 read while empty
        rd(got, oe);
        chk("R5 oe stays low", 16'(oe), 16'd0);
        chk("R5 still empty", 16'(empty_n), 16'd0);

        // R6 read flow-through
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        chk("R6 oe low while empty", 16'(dout_oe), 16'd0);
        wr(9'h03C);
        chk("R6 empty_n after write", 16'(empty_n), 16'd1);
        @(negedge clk);
        chk("R6 oe after write", 16'(dout_oe), 16'd1);
        chk("R6 flow data", 16'(dout), 16'h03C);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R6 oe released", 16'(dout_oe), 16'd0);
        chk("R6 empty again", 16'(empty_n), 16'd0);

        // R8 half flag around DEPTH/2
        do_reset();
        for (int i = 0; i < DEPTH / 2; i++) wr(9'(i));
        chk("R8 half_n at half", 16'(half_n), 16'd1);
        wr(9'(DEPTH / 2));
        chk("R8 half_n above half", 16'(half_n), 16'd0);
        rd(got, oe);
        chk("R8 half_n back at half", 16'(half_n), 16'd1);

        // R9 / R3 full and ignored write
        do_reset();
        for (int i = 0; i < DEPTH; i++) wr(9'(i));
        chk("R9 full_n at depth", 16'(full_n), 16'd0);
        wr(9'h1FF);
        chk("R3 still full", 16'(full_n), 16'd0);
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(got, oe);
            if (!oe || got !== 9'(i)) bad++;
        end
        chk("R3 contents unchanged by write while full", 16'(bad), 16'd0);
        chk("R9 empty after drain", 16'(empty_n), 16'd0);

        // R7 write flow-through
        for (int i = 0; i < DEPTH; i++) wr(9'(i));
        @(negedge clk);
        wr_n = 1'b0;
        din = 9'h0AA;
        rd(got, oe);
        chk("R7 read from full", 16'(got), 16'h000);
        chk("R7 full_n freed", 16'(full_n), 16'd1);
        wr_n = 1'b1;
        @(negedge clk);
        chk("R7 full again", 16'(full_n), 16'd0);
        bad = 0;
        for (int i = 1; i < DEPTH; i++) begin
            rd(got, oe);
            if (got !== 9'(i)) bad++;
        end
        chk("R7 earlier words intact", 16'(bad), 16'd0);
        rd(got, oe);
        chk("R7 flow-through word", 16'(got), 16'h0AA);

        // R10 rewind
        do_reset();
        wr(9'h101); wr(9'h102); wr(9'h103);
        rd(got, oe); rd(got, oe);
        @(negedge clk);
        rewind = 1'b1;
        @(negedge clk);
        rewind = 1'b0;
        rd(got, oe);
        chk("R10 rewind first word", 16'(got), 16'h101);
        rd(got, oe);
        chk("R10 rewind second word", 16'(got), 16'h102);
        rd(got, oe);
        chk("R10 rewind third word", 16'(got), 16'h103);
        chk("R10 level restored to 3", 16'(empty_n), 16'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule